// File: doc/BRIEF.md
# Three-State Condition Register Logic Unit

This block keeps a small register of condition fields, each two bits wide, where every field holds one of three states: undefined, false or true. A request names a logical operation, two source fields and a destination field. The block combines the two source fields under three-valued logic and stores the result in the destination field on the next clock edge. The same value is also presented on a result output.

A parallel port loads all fields at once, and the packed register is always visible on an output. A sequencer uses the block to build compound conditions from simpler ones. How far an undefined operand reaches the result differs between the nine operations. Several operations are deliberately asymmetric in their two operands.

Top module: `tri_cond_unit`

## Requirements
- R1: While reset is held and after it is released, all fields read undefined (`cr_q` = 0) and `result_q` = 0.
- R2: Field k sits at `cr_q[2k+1:2k]`. Codes 0 and 1 mean undefined, 2 means false and 3 means true. Every undefined result is written and output as code 0.
- R3: Opcodes are 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 ANDN, 6 ORN, 7 NANDN and 8 NORN. When `op_valid` is high with a defined opcode and `wr_en` is low, the result is placed in field `dst_idx` and in `result_q` on the next edge, and no other field changes. Sources are read from the register value before that edge, so a source may also be the destination.
- R4: AND and NAND are defined only when A is true and B is defined. AND then gives B and NAND gives the inverse of B. Every other case gives undefined.
- R5: OR gives true when either operand is true. It gives false when neither is true and at least one is false. It gives undefined when both are undefined. NOR gives the inverse of OR and is undefined in the same case.
- R6: XOR gives undefined when A is undefined. When A is false it gives B, which is undefined if B is undefined. When A is true it gives true for an undefined B and the inverse of B otherwise.
- R7: ANDN and NANDN are defined only when A is false and B is defined. ANDN then gives B and NANDN gives the inverse of B. Every other case gives undefined.
- R8: ORN gives undefined when both operands are undefined. When A is undefined it gives B. When A is false it gives true. When A is true it gives true if B is true and false otherwise.
- R9: NORN gives undefined when both operands are undefined. When A is undefined it gives the inverse of B. When A is false it gives false. When A is true it gives false if B is true and true otherwise.
- R10: With `op_valid` high and an opcode from 9 to 15, the register is unchanged and `result_q` becomes 0 on the next edge.
- R11: With `wr_en` high, the whole register takes `wr_data` on the next edge, even when an operation is requested in the same cycle. In that case `result_q` still takes the computed result.
- R12: With both `op_valid` and `wr_en` low, `cr_q` and `result_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 4 | Operation selector |
| src_a_idx | input | IDX_W (3) | Index of first operand field |
| src_b_idx | input | IDX_W (3) | Index of second operand field |
| dst_idx | input | IDX_W (3) | Index of destination field |
| wr_en | input | 1 | Parallel register load strobe |
| wr_data | input | CR_W (16) | Parallel load value |
| cr_q | output | CR_W (16) | Packed condition register |
| result_q | output | 2 | Last computed operation result |

## Verification
The bench builds the block with its default of eight fields and the fixed 4-bit opcode. With these values every source, destination and opcode combination is reachable, including the seven unused opcodes. The bench runs all sixteen opcodes against all sixteen operand code pairs, which covers both undefined codes. It also drives source and destination onto the same field and overlaps a parallel load with an operation in the same cycle. A long random run then mixes operations, loads and idle cycles.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_UNDEF = 2'd0;
    localparam trit_t TRIT_FALSE = 2'd2;
    localparam trit_t TRIT_TRUE  = 2'd3;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND   = 4'd0,
        OP_OR    = 4'd1,
        OP_XOR   = 4'd2,
        OP_NAND  = 4'd3,
        OP_NOR   = 4'd4,
        OP_ANDN  = 4'd5,
        OP_ORN   = 4'd6,
        OP_NANDN = 4'd7,
        OP_NORN  = 4'd8
    } cond_op_e;

    function automatic logic is_def(trit_t t);
        return t[1];
    endfunction

    function automatic logic is_true(trit_t t);
        return t == TRIT_TRUE;
    endfunction

    function automatic logic is_false(trit_t t);
        return t == TRIT_FALSE;
    endfunction

    // flip a defined value, keep undefined canonical
    function automatic trit_t flip(trit_t t);
        return t[1] ? {1'b1, ~t[0]} : TRIT_UNDEF;
    endfunction

    function automatic trit_t canon(trit_t t);
        return t[1] ? t : TRIT_UNDEF;
    endfunction

endpackage

// File: rtl/tcu_field_sel.sv
module tcu_field_sel
    import tcu_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    localparam int IDX_W = $clog2(NUM_FIELDS),
    localparam int CR_W  = 2 * NUM_FIELDS
) (
    input  logic [CR_W-1:0]  cr,
    input  logic [IDX_W-1:0] idx,
    output trit_t            field
);
    trit_t fields [NUM_FIELDS];

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_unpack
        assign fields[k] = cr[2*k +: 2];
    end

    assign field = fields[idx];
endmodule

// File: rtl/tcu_logic.sv
module tcu_logic
    import tcu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  trit_t           a,
    input  trit_t           b,
    output trit_t           res,
    output logic            op_ok
);
    trit_t or_val;
    trit_t orn_val;

    always_comb begin
        // plain OR: true dominates, then false, else undefined
        if (is_true(a) || is_true(b))
            or_val = TRIT_TRUE;
        else if (is_false(a) || is_false(b))
            or_val = TRIT_FALSE;
        else
            or_val = TRIT_UNDEF;

        // OR with first operand inverted
        if (!is_def(a))
            orn_val = canon(b);
        else if (is_false(a))
            orn_val = TRIT_TRUE;
        else
            orn_val = is_true(b) ? TRIT_TRUE : TRIT_FALSE;
    end

    always_comb begin
        op_ok = 1'b1;
        res   = TRIT_UNDEF;
        case (op)
            OP_AND:   res = (is_true(a)  && is_def(b)) ? b       : TRIT_UNDEF;
            OP_NAND:  res = (is_true(a)  && is_def(b)) ? flip(b) : TRIT_UNDEF;
            OP_ANDN:  res = (is_false(a) && is_def(b)) ? b       : TRIT_UNDEF;
            OP_NANDN: res = (is_false(a) && is_def(b)) ? flip(b) : TRIT_UNDEF;
            OP_OR:    res = or_val;
            OP_NOR:   res = flip(or_val);
            OP_ORN:   res = orn_val;
            OP_NORN:  res = flip(orn_val);
            OP_XOR: begin
                if (!is_def(a))
                    res = TRIT_UNDEF;
                else if (is_false(a))
                    res = canon(b);
                else
                    res = is_def(b) ? flip(b) : TRIT_TRUE;
            end
            default: begin
                op_ok = 1'b0;
                res   = TRIT_UNDEF;
            end
        endcase
    end
endmodule

// File: rtl/tcu_field_write.sv
module tcu_field_write
    import tcu_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    localparam int IDX_W = $clog2(NUM_FIELDS),
    localparam int CR_W  = 2 * NUM_FIELDS
) (
    input  logic [CR_W-1:0]  cr_in,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  trit_t            val,
    output logic [CR_W-1:0]  cr_out
);
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        assign cr_out[2*k +: 2] = (en && (idx == IDX_W'(k))) ? val : cr_in[2*k +: 2];
    end
endmodule

// File: rtl/tri_cond_unit.sv
module tri_cond_unit
    import tcu_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    localparam int IDX_W = $clog2(NUM_FIELDS),
    localparam int CR_W  = 2 * NUM_FIELDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             wr_en,
    input  logic [CR_W-1:0]  wr_data,
    output logic [CR_W-1:0]  cr_q,
    output logic [1:0]       result_q
);
    typedef struct packed {
        logic [CR_W-1:0] cr;
        trit_t           res;
    } state_t;

    state_t st_d, st_q;

    trit_t           opnd_a, opnd_b, op_res;
    logic            op_ok;
    logic [CR_W-1:0] cr_upd;

    tcu_field_sel #(.NUM_FIELDS(NUM_FIELDS)) u_sel_a (
        .cr(st_q.cr), .idx(src_a_idx), .field(opnd_a)
    );

    tcu_field_sel #(.NUM_FIELDS(NUM_FIELDS)) u_sel_b (
        .cr(st_q.cr), .idx(src_b_idx), .field(opnd_b)
    );

    tcu_logic u_logic (
        .op(op_code), .a(opnd_a), .b(opnd_b), .res(op_res), .op_ok(op_ok)
    );

    tcu_field_write #(.NUM_FIELDS(NUM_FIELDS)) u_write (
        .cr_in(st_q.cr), .en(op_valid && op_ok), .idx(dst_idx),
        .val(op_res), .cr_out(cr_upd)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid)
            st_d.res = op_res;
        if (wr_en)
            st_d.cr = wr_data;
        else
            st_d.cr = cr_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cr_q     = st_q.cr;
    assign result_q = st_q.res;
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker
    import tcu_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    localparam int IDX_W = $clog2(NUM_FIELDS),
    localparam int CR_W  = 2 * NUM_FIELDS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [OP_W-1:0]  op_code,
    input logic [IDX_W-1:0] dst_idx,
    input logic             wr_en,
    input logic [CR_W-1:0]  wr_data,
    input logic [CR_W-1:0]  cr_q,
    input logic [1:0]       result_q
);
    logic            known_op;
    logic [CR_W-1:0] keep_mask_q;

    assign known_op = op_code <= 4'd8;

    always_ff @(posedge clk) begin
        keep_mask_q <= ~(CR_W'(2'b11) << (2 * dst_idx));
    end

    // R2: undefined results come out as code 0, never code 1
    p_canon_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_q != 2'b01);

    // R11: parallel load wins
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cr_q == $past(wr_data));

    // R12: idle cycles hold everything
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !wr_en) |=> ($stable(cr_q) && $stable(result_q)));

    // R10: unknown opcodes leave the register alone and report undefined
    p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && !known_op) |=> ($stable(cr_q) && result_q == 2'b00));

    // R3: only the destination field may change
    p_one_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && known_op) |=> (((cr_q ^ $past(cr_q)) & keep_mask_q) == '0));

    // R3: destination field equals the reported result
    p_dst_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && known_op) |=> (((cr_q >> (2 * $past(dst_idx))) & CR_W'(3)) == CR_W'(result_q)));
endmodule

bind tri_cond_unit tcu_checker #(.NUM_FIELDS(NUM_FIELDS)) u_tcu_checker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_idx(dst_idx), .wr_en(wr_en), .wr_data(wr_data),
    .cr_q(cr_q), .result_q(result_q)
);

// File: tb/tb_tri_cond_unit.sv
module tb_tri_cond_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NF   = 8;
    localparam int IW   = 3;
    localparam int CW   = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_valid;
    logic [3:0]    op_code;
    logic [IW-1:0] src_a_idx, src_b_idx, dst_idx;
    logic          wr_en;
    logic [CW-1:0] wr_data;
    logic [CW-1:0] cr_q;
    logic [1:0]    result_q;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    logic [CW-1:0] m_cr;
    logic [1:0]    m_res;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_cond_unit #(.NUM_FIELDS(NF)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .wr_en(wr_en), .wr_data(wr_data), .cr_q(cr_q), .result_q(result_q)
    );

    // behavioural model: -1 undefined, 0 false, 1 true
    function automatic int dec(int c);
        return (c < 2) ? -1 : c - 2;
    endfunction

    function automatic int enc(int v);
        return (v < 0) ? 0 : v + 2;
    endfunction

    function automatic int ref_op(int op, int ca, int cb);
        int a = dec(ca);
        int b = dec(cb);
        int r = -1;
        case (op)
            0: r = (a == 1 && b >= 0) ? b : -1;
            3: r = (a == 1 && b >= 0) ? 1 - b : -1;
            5: r = (a == 0 && b >= 0) ? b : -1;
            7: r = (a == 0 && b >= 0) ? 1 - b : -1;
            1, 4: begin
                if (a == 1 || b == 1) r = 1;
                else if (a == 0 || b == 0) r = 0;
                else r = -1;
                if (op == 4 && r >= 0) r = 1 - r;
            end
            2: begin
                if (a < 0) r = -1;
                else if (a == 0) r = b;
                else r = (b < 0) ? 1 : 1 - b;
            end
            6, 8: begin
                if (a < 0 && b < 0) r = -1;
                else if (a < 0) r = b;
                else if (a == 0) r = 1;
                else r = (b == 1) ? 1 : 0;
                if (op == 8 && r >= 0) r = 1 - r;
            end
            default: r = -1;
        endcase
        return enc(r);
    endfunction

    function automatic string tag_of(int op, logic wr);
        if (wr) return "R11";
        case (op)
            0, 3: return "R4";
            1, 4: return "R5";
            2:    return "R6";
            5, 7: return "R7";
            6:    return "R8";
            8:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag);
        vectors++;
        if (cr_q !== m_cr || result_q !== m_res) begin
            errors++;
            $display("FAIL %s: cr_q=%h result_q=%0d expected cr_q=%h result_q=%0d",
                     tag, cr_q, result_q, m_cr, m_res);
        end
    endtask

    // drive one cycle, advance the model at the edge, compare after it
    task automatic cycle(logic v, int op, int sa, int sb, int d, logic w, logic [CW-1:0] wd,
                         string tag);
        int ca, cb, r;
        op_valid = v; op_code = 4'(op);
        src_a_idx = IW'(sa); src_b_idx = IW'(sb); dst_idx = IW'(d);
        wr_en = w; wr_data = wd;
        ca = int'(m_cr[2*sa +: 2]);
        cb = int'(m_cr[2*sb +: 2]);
        r  = ref_op(op, ca, cb);
        @(posedge clk);
        if (v) m_res = 2'(r);
        if (w) m_cr = wd;
        else if (v && op <= 8) m_cr[2*d +: 2] = 2'(r);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0;
        src_a_idx = '0; src_b_idx = '0; dst_idx = '0; wr_en = 1'b0; wr_data = '0;
        m_cr = '0; m_res = '0;
        repeat (3) @(negedge clk);
        check("R1");
        // stimulus during reset must not stick
        op_valid = 1'b1; wr_en = 1'b1; wr_data = 16'hFFFF;
        @(negedge clk);
        check("R1");
        op_valid = 1'b0; wr_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // exhaustive opcode x operand codes (R2 covers both undefined codes)
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    logic [CW-1:0] ld = 16'h5A5A;
                    int dst = (op + a + b) % NF;
                    ld[2*2 +: 2] = 2'(a);
                    ld[2*5 +: 2] = 2'(b);
                    cycle(1'b0, 0, 0, 0, 0, 1'b1, ld, "R11");
                    cycle(1'b1, op, 2, 5, dst, 1'b0, '0, tag_of(op, 1'b0));
                end
            end
        end

        // R3: source equals destination uses the pre-edge value
        cycle(1'b0, 0, 0, 0, 0, 1'b1, 16'h00C0, "R11");
        cycle(1'b1, 3, 3, 3, 3, 1'b0, '0, "R3");
        cycle(1'b1, 3, 3, 3, 3, 1'b0, '0, "R3");

        // R11: load and operation in the same cycle
        cycle(1'b1, 1, 3, 3, 0, 1'b1, 16'h1234, "R11");
        // R12: idle holds
        cycle(1'b0, 1, 1, 2, 3, 1'b0, 16'hFFFF, "R12");
        cycle(1'b0, 9, 4, 5, 6, 1'b0, 16'h0000, "R12");
        // R10: unused opcode
        cycle(1'b1, 15, 1, 2, 4, 1'b0, '0, "R10");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int  op = $urandom_range(0, 15);
            logic v = ($urandom_range(0, 3) != 0);
            logic w = ($urandom_range(0, 7) == 0);
            string t = v ? tag_of(op, w) : (w ? "R11" : "R12");
            if (v && !w && op <= 8 && $urandom_range(0, 3) == 0) t = "R3";
            cycle(v, op, $urandom_range(0, NF-1), $urandom_range(0, NF-1),
                  $urandom_range(0, NF-1), w, 16'($urandom), t);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule